// File: doc/BRIEF.md
# SRAM ECC Error Capture Unit

This block places a 64-bit-wide on-chip SRAM behind single-error-correct, double-error-detect protection. Each stored doubleword carries eight check bits. Seven Hamming parity bits sit at the power-of-two code positions, and one overall parity bit covers the whole 72-bit word. The check bits are computed on every write and evaluated on every read. A single flipped bit is repaired before the data leaves the block, so software takes no action for it. Two flipped bits are flagged as uncorrectable, and an exception line toward the processor rises.

The block also serves as an error reporting point. Two software enables decide whether corrected events, uncorrectable events, or both are reported. A reported event raises an interrupt request and loads a set of read-only capture registers. These hold the raw doubleword as it came off the array, the word address and a two-bit event type. Software reads them as 32-bit words through a small select port. Memory contents are unknown after reset, so every location must be written with a full doubleword before its first read. A fault-injection mask on the write port lets chosen stored bits be inverted so that the correction path can be exercised.

Top module: `sram_ecc_capture`

## Requirements
- R1: A read issued with `rdEn` high and `wrEn` low returns the written doubleword on `rdData` with `rdValid` high exactly one clock later. In that cycle both error flags are low when no stored bit was inverted.
- R2: Stored bit k is the doubleword bit k for k in 0..63, and the check bits for k in 64..71. Bit 71 is the overall parity bit. `wrInjMask` bit k inverts stored bit k on that write. When exactly one data bit is inverted, the read returns the original data with `corrFlag` high and `uncorrFlag` low.
- R3: When exactly one check bit is inverted, including the overall parity bit, the read returns the data unchanged with `corrFlag` high.
- R4: When two stored bits are inverted, the read raises `uncorrFlag` with `corrFlag` low. `mbeExc` is high in that same cycle whatever the enables are.
- R5: `irqReq` is high during a read response cycle exactly when (`corrFlag` and `corrRptEn`) or (`uncorrFlag` and `uncorrRptEn`). The enables are sampled in that response cycle.
- R6: After a reported event, `capSel`=0 returns bits 31:0 and `capSel`=1 returns bits 63:32 of the stored data as read from the array, before correction.
- R7: After a reported event, `capSel`=2 returns the word address of that access, zero-extended. `capSel`=3 returns the event type in bits 1:0: 01 for corrected and 10 for uncorrectable.
- R8: An event whose reporting enable is low leaves all capture registers unchanged.
- R9: A later reported event overwrites the capture registers of an earlier one.
- R10: After reset, `rdValid`, `irqReq` and `mbeExc` are low and the captured event type reads 00. The captured data value is undefined.
- R11: When `wrEn` and `rdEn` are high in the same cycle, the write is performed and no read response follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address for read or write |
| wrEn | input | 1 | Write strobe, has priority over read |
| rdEn | input | 1 | Read strobe |
| wrData | input | 64 | Write doubleword |
| wrInjMask | input | 72 | Stored-bit inversion mask applied on write |
| corrRptEn | input | 1 | Report enable for corrected events |
| uncorrRptEn | input | 1 | Report enable for uncorrectable events |
| capSel | input | 2 | Capture register select |
| rdValid | output | 1 | Read response valid |
| rdData | output | 64 | Corrected read doubleword |
| corrFlag | output | 1 | Corrected single-bit event on this response |
| uncorrFlag | output | 1 | Uncorrectable event on this response |
| irqReq | output | 1 | Interrupt request for a reported event |
| mbeExc | output | 1 | Exception for an uncorrectable event |
| capRdData | output | 32 | Selected capture register contents |

## Verification
A wrong syndrome-to-bit mapping shows up in the very response cycle of the read, either as a wrong `rdData` bit or as a flag of the wrong class. The bench therefore compares every response against a scoreboard built from the written data and the injected mask. A capture register that loads when it should not, or fails to load when it should, is invisible on the read path. It shows only on `capRdData` one cycle after the response, so the capture registers are read back after every event, whether enabled or not. An inverted priority between write and read shows as a stray `rdValid` one cycle after a colliding access.

// File: rtl/sram_ecc_pkg.sv
package sram_ecc_pkg;
  localparam int DATA_W = 64;
  localparam int SYN_W  = 7;
  localparam int CHK_W  = SYN_W + 1;
  localparam int WORD_W = DATA_W + CHK_W;

  typedef enum logic [1:0] {
    EV_NONE   = 2'b00,
    EV_CORR   = 2'b01,
    EV_UNCORR = 2'b10
  } evType_t;

  typedef struct packed {
    logic    capLoad;
    evType_t capType;
  } ctrlStrb_t;

  // Code position of data bit idx: the idx-th position from 3 upward that is not a power of two
  function automatic logic [SYN_W-1:0] posOf(input int idx);
    int cnt;
    logic [SYN_W-1:0] res;
    cnt = 0;
    res = '0;
    for (int p = 3; p < WORD_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == idx) res = SYN_W'(p);
        cnt++;
      end
    end
    return res;
  endfunction

  function automatic logic [SYN_W-1:0] hamSyn(input logic [DATA_W-1:0] d);
    logic [SYN_W-1:0] s;
    s = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (d[i]) s = s ^ posOf(i);
    end
    return s;
  endfunction

  function automatic logic [CHK_W-1:0] eccEncode(input logic [DATA_W-1:0] d);
    logic [SYN_W-1:0] h;
    h = hamSyn(d);
    return {^{d, h}, h};
  endfunction
endpackage

// File: rtl/ecc_ctrl.sv
module ecc_ctrl
  import sram_ecc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      rdValid,
  input  logic      sbeIn,
  input  logic      mbeIn,
  input  logic      corrRptEn,
  input  logic      uncorrRptEn,
  output ctrlStrb_t strb,
  output logic      irqReq,
  output logic      mbeExc
);
  logic repEvent;

  always_comb begin
    repEvent     = (sbeIn && corrRptEn) || (mbeIn && uncorrRptEn);
    strb.capLoad = repEvent;
    strb.capType = mbeIn ? EV_UNCORR : EV_CORR;
    irqReq       = repEvent;
    mbeExc       = mbeIn;
  end

  // R5
  irq_in_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> rdValid);

  // R2
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(sbeIn && mbeIn));

  // R4
  exc_in_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    mbeExc |-> rdValid);
endmodule

// File: rtl/ecc_datapath.sv
module ecc_datapath
  import sram_ecc_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [WORD_W-1:0] wrInjMask,
  input  ctrlStrb_t         strb,
  input  logic [1:0]        capSel,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              sbeOut,
  output logic              mbeOut,
  output logic [31:0]       capRdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] memQ [DEPTH];
  logic [WORD_W-1:0] rdWordQ;
  logic [ADDR_W-1:0] rdAddrQ;
  logic              rdValidQ;
  logic [DATA_W-1:0] capDataQ;
  logic [ADDR_W-1:0] capAddrQ;
  evType_t           capTypeQ;

  logic [DATA_W-1:0] stData;
  logic [SYN_W-1:0]  syn;
  logic              oddPar;
  logic [DATA_W-1:0] corrData;
  logic              sbe;
  logic              mbe;

  always_ff @(posedge clk) begin
    if (wrEn) memQ[addr] <= {eccEncode(wrData), wrData} ^ wrInjMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdValidQ <= 1'b0;
    else       rdValidQ <= rdEn && !wrEn;
  end

  always_ff @(posedge clk) begin
    if (rdEn && !wrEn) begin
      rdWordQ <= memQ[addr];
      rdAddrQ <= addr;
    end
  end

  always_comb begin
    stData   = rdWordQ[DATA_W-1:0];
    syn      = hamSyn(stData) ^ rdWordQ[DATA_W +: SYN_W];
    oddPar   = ^rdWordQ;
    corrData = stData;
    sbe      = 1'b0;
    mbe      = 1'b0;
    if (oddPar) begin
      if ((syn & (syn - SYN_W'(1))) == '0) begin
        sbe = 1'b1;
      end else if (int'(syn) >= WORD_W) begin
        mbe = 1'b1;
      end else begin
        sbe = 1'b1;
        for (int i = 0; i < DATA_W; i++) begin
          if (posOf(i) == syn) corrData[i] = ~stData[i];
        end
      end
    end else if (syn != '0) begin
      mbe = 1'b1;
    end
  end

  assign rdValid = rdValidQ;
  assign rdData  = corrData;
  assign sbeOut  = rdValidQ && sbe;
  assign mbeOut  = rdValidQ && mbe;

  always_ff @(posedge clk) begin
    if (strb.capLoad) capDataQ <= stData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capAddrQ <= '0;
      capTypeQ <= EV_NONE;
    end else if (strb.capLoad) begin
      capAddrQ <= rdAddrQ;
      capTypeQ <= strb.capType;
    end
  end

  always_comb begin
    unique case (capSel)
      2'd0:    capRdData = capDataQ[31:0];
      2'd1:    capRdData = capDataQ[63:32];
      2'd2:    capRdData = 32'(capAddrQ);
      default: capRdData = {30'b0, capTypeQ};
    endcase
  end

  // R1
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValidQ |-> $past(rdEn && !wrEn));

  // R11
  wr_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !rdValidQ);

  // R8
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capLoad |=> ($stable(capAddrQ) && $stable(capTypeQ)));

  // R7
  cap_type_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capLoad |=> (capTypeQ != EV_NONE));
endmodule

// File: rtl/sram_ecc_capture.sv
module sram_ecc_capture
  import sram_ecc_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [63:0]       wrData,
  input  logic [71:0]       wrInjMask,
  input  logic              corrRptEn,
  input  logic              uncorrRptEn,
  input  logic [1:0]        capSel,
  output logic              rdValid,
  output logic [63:0]       rdData,
  output logic              corrFlag,
  output logic              uncorrFlag,
  output logic              irqReq,
  output logic              mbeExc,
  output logic [31:0]       capRdData
);
  ctrlStrb_t strb;

  ecc_datapath #(.ADDR_W(ADDR_W)) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .addr      (addr),
    .wrEn      (wrEn),
    .rdEn      (rdEn),
    .wrData    (wrData),
    .wrInjMask (wrInjMask),
    .strb      (strb),
    .capSel    (capSel),
    .rdValid   (rdValid),
    .rdData    (rdData),
    .sbeOut    (corrFlag),
    .mbeOut    (uncorrFlag),
    .capRdData (capRdData)
  );

  ecc_ctrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .rdValid     (rdValid),
    .sbeIn       (corrFlag),
    .mbeIn       (uncorrFlag),
    .corrRptEn   (corrRptEn),
    .uncorrRptEn (uncorrRptEn),
    .strb        (strb),
    .irqReq      (irqReq),
    .mbeExc      (mbeExc)
  );
endmodule

// File: tb/test_sram_ecc_capture.sv
module test_sram_ecc_capture;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 6;

  typedef struct {
    logic [63:0] data;
    logic        chkData;
    logic        sbe;
    logic        mbe;
    logic        irq;
    logic        exc;
    int          cyc;
  } expItem_t;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              wrEn = 1'b0;
  logic              rdEn = 1'b0;
  logic [63:0]       wrData = '0;
  logic [71:0]       wrInjMask = '0;
  logic              corrRptEn = 1'b0;
  logic              uncorrRptEn = 1'b0;
  logic [1:0]        capSel = '0;
  logic              rdValid;
  logic [63:0]       rdData;
  logic              corrFlag;
  logic              uncorrFlag;
  logic              irqReq;
  logic              mbeExc;
  logic [31:0]       capRdData;

  expItem_t expQ[$];
  int checks = 0;
  int errors = 0;
  int cycle = 0;
  logic [63:0] patMem [8];
  logic [71:0] maskMem [8];

  sram_ecc_capture #(.ADDR_W(ADDR_W)) i_sram_ecc_capture (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .wrInjMask(wrInjMask), .corrRptEn(corrRptEn),
    .uncorrRptEn(uncorrRptEn), .capSel(capSel), .rdValid(rdValid),
    .rdData(rdData), .corrFlag(corrFlag), .uncorrFlag(uncorrFlag),
    .irqReq(irqReq), .mbeExc(mbeExc), .capRdData(capRdData)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cycle <= cycle + 1;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Monitor: pops one expected item per response
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        check("R11 unexpected response", 64'(rdValid), 64'd0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check("R1 latency", 64'(cycle), 64'(e.cyc + 1));
        if (e.chkData) check("R1/R2/R3 rdData", rdData, e.data);
        check("R2/R3 corrFlag", 64'(corrFlag), 64'(e.sbe));
        check("R4 uncorrFlag", 64'(uncorrFlag), 64'(e.mbe));
        check("R5 irqReq", 64'(irqReq), 64'(e.irq));
        check("R4 mbeExc", 64'(mbeExc), 64'(e.exc));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  task automatic doWrite(input int a, input logic [63:0] d, input logic [71:0] m);
    addr = ADDR_W'(a); wrData = d; wrInjMask = m; wrEn = 1'b1;
    @(posedge clk); #1;
    wrEn = 1'b0; wrInjMask = '0;
  endtask

  // Driver: issues a read and pushes the expected response
  task automatic doRead(input int a, input logic [63:0] d, input logic s, input logic m);
    expItem_t e;
    e.data = d; e.chkData = !m; e.sbe = s; e.mbe = m;
    e.irq = (s && corrRptEn) || (m && uncorrRptEn);
    e.exc = m; e.cyc = cycle;
    expQ.push_back(e);
    addr = ADDR_W'(a); rdEn = 1'b1;
    @(posedge clk); #1;
    rdEn = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic chkCap(input string tag, input logic [63:0] raw, input int a, input logic [1:0] t);
    capSel = 2'd0; #1; check({tag, " R6 cap low"}, 64'(capRdData), 64'(raw[31:0]));
    capSel = 2'd1; #1; check({tag, " R6 cap high"}, 64'(capRdData), 64'(raw[63:32]));
    capSel = 2'd2; #1; check({tag, " R7 cap addr"}, 64'(capRdData), 64'(a));
    capSel = 2'd3; #1; check({tag, " R7 cap type"}, 64'(capRdData), 64'(t));
  endtask

  function automatic logic [71:0] bitMask(input int k);
    return 72'(1) << k;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    check("R10 rdValid", 64'(rdValid), 64'd0);
    check("R10 irqReq", 64'(irqReq), 64'd0);
    check("R10 mbeExc", 64'(mbeExc), 64'd0);
    capSel = 2'd3; #1;
    check("R10 cap type", 64'(capRdData), 64'd0);
    rstN = 1'b1;
    @(posedge clk); #1;

    maskMem[0] = '0;
    maskMem[1] = bitMask(0);
    maskMem[2] = bitMask(63);
    maskMem[3] = bitMask(67);
    maskMem[4] = bitMask(71);
    maskMem[5] = bitMask(5) | bitMask(40);
    maskMem[6] = bitMask(10) | bitMask(65);
    maskMem[7] = bitMask(22);
    for (int a = 0; a < 8; a++) begin
      patMem[a] = {8{8'(a * 37 + 5)}} ^ 64'hF0E1_D2C3_B4A5_9687;
      doWrite(a, patMem[a], maskMem[a]);
    end

    corrRptEn = 1'b1; uncorrRptEn = 1'b1;
    // R1 clean read
    doRead(0, patMem[0], 1'b0, 1'b0);
    check("R8 no event keeps type", 64'(capRdData), 64'd0);
    // R2 data bit errors
    doRead(1, patMem[1], 1'b1, 1'b0);
    chkCap("R2 bit0", patMem[1] ^ maskMem[1][63:0], 1, 2'b01);
    doRead(2, patMem[2], 1'b1, 1'b0);
    chkCap("R9 bit63", patMem[2] ^ maskMem[2][63:0], 2, 2'b01);
    // R3 check-bit errors
    doRead(3, patMem[3], 1'b1, 1'b0);
    chkCap("R3 chk", patMem[3], 3, 2'b01);
    doRead(4, patMem[4], 1'b1, 1'b0);
    // R4 double error, overwrites earlier capture (R9)
    doRead(5, patMem[5], 1'b0, 1'b1);
    chkCap("R9 double", patMem[5] ^ maskMem[5][63:0], 5, 2'b10);
    // R8 uncorrectable disabled: exception still, capture unchanged
    uncorrRptEn = 1'b0;
    doRead(6, patMem[6], 1'b0, 1'b1);
    chkCap("R8 mbe off", patMem[5] ^ maskMem[5][63:0], 5, 2'b10);
    // R8 corrected disabled
    corrRptEn = 1'b0; uncorrRptEn = 1'b1;
    doRead(7, patMem[7], 1'b1, 1'b0);
    chkCap("R8 sbe off", patMem[5] ^ maskMem[5][63:0], 5, 2'b10);
    // R5 corrected reported again
    corrRptEn = 1'b1;
    doRead(7, patMem[7], 1'b1, 1'b0);
    chkCap("R5 sbe on", patMem[7] ^ maskMem[7][63:0], 7, 2'b01);

    // R11 write wins over simultaneous read
    addr = ADDR_W'(9); wrData = 64'hDEAD_BEEF_0BAD_F00D; wrEn = 1'b1; rdEn = 1'b1;
    @(posedge clk); #1;
    wrEn = 1'b0; rdEn = 1'b0;
    @(negedge clk);
    check("R11 no response", 64'(rdValid), 64'd0);
    @(posedge clk); #1;
    doRead(9, 64'hDEAD_BEEF_0BAD_F00D, 1'b0, 1'b0);

    repeat (2) @(posedge clk);
    check("R1 queue drained", 64'(expQ.size()), 64'd0);
    finishRun();
  end
endmodule